// File: doc/BRIEF.md
# Converter Control and Byte-Multiplexed Readout

This block is the digital front end of a 12-bit, eight-channel data-acquisition converter. It connects to a shared 8-bit host bus through active-low chip-select, write-strobe and read-strobe inputs and a high-byte select. A host write stores a control byte. The control byte picks the input channel, the range and polarity, how acquisition ends, and the clock or power-down mode. Once a normal-mode byte is written, the block runs an acquisition phase and then a conversion phase. At the end of conversion it captures the 12-bit code that the conversion core presents.

Each host read returns one byte of the stored result. The high-byte select chooses which byte. In the high byte, the four upper bus bits are either zero-filled or sign-extended, depending on the polarity the result was converted with. The bus is modelled as a separate output and an output-enable pair, so the pads outside the block perform the actual three-stating.

Top module: `daq_host_front`

## Requirements
- R1: After reset the control state is all zero: `chanSel`=0, `rangeWide`=0, `bipolarSel`=0, `intClk`=0, `standby`=0, `fullPd`=0. In addition, `busyN`=1, `busOe`=0, and the stored result reads 0 in both bytes.
- R2: A write event is the first clock cycle in which `csN`=0 and `wrN`=0 after `wrN` was high. On a write event the block latches `busIn`. Bits [2:0] of that byte become `chanSel`, bit 3 becomes `bipolarSel`, bit 4 becomes `rangeWide`, bit 5 selects host-ended acquisition, and bits [7:6] are the mode field. Between write events these outputs do not change.
- R3: While `csN`=1, `wrN` and `rdN` have no effect and `busOe` stays 0.
- R4: A write with mode bit 7 = 0 and bit 5 = 0 starts an internally timed acquisition of exactly 6 cycles, followed by 12 conversion cycles. `busyN` is low for 18 cycles, starting at the write edge and ending at the edge that loads the result.
- R5: A write with mode bit 7 = 0 and bit 5 = 1 holds acquisition (`sampling`=1, `busyN`=0) until the next write. If that write has bit 5 = 0, mode bit 7 = 0 and the same channel, conversion starts and `busyN` returns high 12 cycles after that write edge. Any other normal-mode write during this wait restarts acquisition with the new byte.
- R6: A read with `csN`=0, `rdN`=0 and `byteHiSel`=0 drives result bits [7:0] with `busOe`=1.
- R7: A read with `byteHiSel`=1 drives result bits [11:8] on bus bits [3:0]. Bus bits [7:4] are 0 if the result was converted unipolar (bit 3 = 0). They are copies of result bit 11 if it was converted bipolar.
- R8: Mode field 00 sets `intClk`=0 and mode field 01 sets `intClk`=1. Mode field 10 sets `standby` and mode field 11 sets `fullPd`. Both power-down codes leave `intClk` unchanged.
- R9: A write with mode bit 7 = 1 aborts any acquisition or conversion. `busyN` is high from the next cycle, no conversion starts, and the previous result stays readable.
- R10: The result register loads `rawResult` as sampled on the final conversion edge. It does not change at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| byteHiSel | input | 1 | Selects the high result byte on a read |
| busIn | input | 8 | Bus data from the host |
| busOut | output | 8 | Bus data to the host |
| busOe | output | 1 | Bus output enable; 0 means high impedance |
| rawResult | input | 12 | Code from the conversion core |
| busyN | output | 1 | Low while acquiring or converting |
| sampling | output | 1 | Acquisition phase active |
| converting | output | 1 | Conversion phase active |
| chanSel | output | 3 | Selected input channel |
| rangeWide | output | 1 | 1 selects the 10 V span, 0 the 5 V span |
| bipolarSel | output | 1 | 1 selects bipolar, two's-complement coding |
| standby | output | 1 | Standby power-down selected |
| fullPd | output | 1 | Full power-down selected |
| intClk | output | 1 | Internal conversion clock selected |

## Verification
The main flow is exercised with a set of control bytes that covers each range and polarity combination. Each byte is paired with a raw code whose top bit is either set or clear. This separates zero fill from sign extension, and the low byte from the high byte. The codes 0x7FF and 0x800 sit on either side of the sign boundary and expose an off-by-one in the fill source. Directed runs then cover host-ended acquisition, where a second write with the same channel starts conversion. They also cover a power-down write that lands mid-conversion, and writes and reads with chip-select high, which must leave state and bus untouched.

// File: rtl/daq_front_pkg.sv
package daq_front_pkg;
  localparam int MODE_HI_BIT = 7;
  localparam int MODE_LO_BIT = 6;
  localparam int ACQ_EXT_BIT = 5;
  localparam int RANGE_BIT   = 4;
  localparam int BIPOLAR_BIT = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ_INT,
    ST_ACQ_EXT,
    ST_CONV
  } seqState_t;

  typedef struct packed {
    logic ctrlLoad;
    logic resultLoad;
  } seqStrobe_t;
endpackage

// File: rtl/daq_seq_ctrl.sv
module daq_seq_ctrl
  import daq_front_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CH_W        = 3,
  parameter int ACQ_CYCLES  = 6,
  parameter int CONV_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] busIn,
  input  logic [CH_W-1:0]   curChan,
  output seqStrobe_t        strobe,
  output logic              busyN,
  output logic              sampling,
  output logic              converting
);
  localparam int MAX_CYC = (ACQ_CYCLES > CONV_CYCLES) ? ACQ_CYCLES : CONV_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CYCLES - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYCLES - 1);

  seqState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             wrPrev;
  logic             wrEvt;
  logic             newPd, newAcqExt, sameChan;

  assign wrEvt     = !csN && !wrN && wrPrev;
  assign newPd     = busIn[MODE_HI_BIT];
  assign newAcqExt = busIn[ACQ_EXT_BIT];
  assign sameChan  = (busIn[CH_W-1:0] == curChan);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    strobe    = '0;
    strobe.ctrlLoad = wrEvt;
    if (wrEvt) begin
      cntNext = '0;
      if (newPd) begin
        stateNext = ST_IDLE;
      end else if (state == ST_ACQ_EXT && !newAcqExt && sameChan) begin
        stateNext = ST_CONV;
      end else begin
        stateNext = newAcqExt ? ST_ACQ_EXT : ST_ACQ_INT;
      end
    end else begin
      unique case (state)
        ST_ACQ_INT: begin
          if (cnt == ACQ_LAST) begin
            stateNext = ST_CONV;
            cntNext   = '0;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        ST_CONV: begin
          if (cnt == CONV_LAST) begin
            stateNext         = ST_IDLE;
            cntNext           = '0;
            strobe.resultLoad = 1'b1;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      wrPrev <= 1'b1;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      wrPrev <= wrN;
    end
  end

  assign sampling   = (state == ST_ACQ_INT) || (state == ST_ACQ_EXT);
  assign converting = (state == ST_CONV);
  assign busyN      = (state == ST_IDLE);
endmodule

// File: rtl/daq_result_path.sv
module daq_result_path
  import daq_front_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RES_W  = 12,
  parameter int CH_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] busIn,
  input  logic [RES_W-1:0]  rawResult,
  input  logic              csN,
  input  logic              rdN,
  input  logic              byteHiSel,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [CH_W-1:0]   chanSel,
  output logic              rangeWide,
  output logic              bipolarSel,
  output logic              standby,
  output logic              fullPd,
  output logic              intClk
);
  localparam int HI_W   = RES_W - DATA_W;
  localparam int FILL_W = DATA_W - HI_W;

  logic [DATA_W-1:0] ctrlReg;
  logic              intClkReg;
  logic [RES_W-1:0]  resultReg;
  logic              resBipolar;
  logic [FILL_W-1:0] fillBits;
  logic [HI_W-1:0]   hiRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      intClkReg <= 1'b0;
    end else if (strobe.ctrlLoad) begin
      ctrlReg <= busIn;
      if (!busIn[MODE_HI_BIT]) intClkReg <= busIn[MODE_LO_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultReg  <= '0;
      resBipolar <= 1'b0;
    end else if (strobe.resultLoad) begin
      resultReg  <= rawResult;
      resBipolar <= ctrlReg[BIPOLAR_BIT];
    end
  end

  assign hiRaw = resultReg[RES_W-1:DATA_W];

  for (genvar i = 0; i < FILL_W; i++) begin : g_fill
    assign fillBits[i] = resBipolar & resultReg[RES_W-1];
  end

  assign busOe  = !csN && !rdN;
  assign busOut = byteHiSel ? {fillBits, hiRaw} : resultReg[DATA_W-1:0];

  assign chanSel    = ctrlReg[CH_W-1:0];
  assign bipolarSel = ctrlReg[BIPOLAR_BIT];
  assign rangeWide  = ctrlReg[RANGE_BIT];
  assign standby    = ctrlReg[MODE_HI_BIT] && !ctrlReg[MODE_LO_BIT];
  assign fullPd     = ctrlReg[MODE_HI_BIT] && ctrlReg[MODE_LO_BIT];
  assign intClk     = intClkReg;
endmodule

// File: rtl/daq_host_front.sv
module daq_host_front
  import daq_front_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int RES_W       = 12,
  parameter int CH_W        = 3,
  parameter int ACQ_CYCLES  = 6,
  parameter int CONV_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  input  logic              byteHiSel,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  input  logic [RES_W-1:0]  rawResult,
  output logic              busyN,
  output logic              sampling,
  output logic              converting,
  output logic [CH_W-1:0]   chanSel,
  output logic              rangeWide,
  output logic              bipolarSel,
  output logic              standby,
  output logic              fullPd,
  output logic              intClk
);
  seqStrobe_t strobe;

  daq_seq_ctrl #(
    .DATA_W(DATA_W), .CH_W(CH_W),
    .ACQ_CYCLES(ACQ_CYCLES), .CONV_CYCLES(CONV_CYCLES)
  ) ctrlPath (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .busIn(busIn),
    .curChan(chanSel), .strobe(strobe), .busyN(busyN),
    .sampling(sampling), .converting(converting)
  );

  daq_result_path #(
    .DATA_W(DATA_W), .RES_W(RES_W), .CH_W(CH_W)
  ) dataPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busIn(busIn),
    .rawResult(rawResult), .csN(csN), .rdN(rdN), .byteHiSel(byteHiSel),
    .busOut(busOut), .busOe(busOe), .chanSel(chanSel),
    .rangeWide(rangeWide), .bipolarSel(bipolarSel), .standby(standby),
    .fullPd(fullPd), .intClk(intClk)
  );
endmodule

// File: rtl/daq_host_front_chk.sv
module daq_host_front_chk #(
  parameter int DATA_W = 8,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              wrN,
  input logic              byteHiSel,
  input logic [DATA_W-1:0] busIn,
  input logic [DATA_W-1:0] busOut,
  input logic              busOe,
  input logic              busyN,
  input logic              sampling,
  input logic              converting,
  input logic [CH_W-1:0]   chanSel,
  input logic              rangeWide,
  input logic              bipolarSel,
  input logic              standby,
  input logic              fullPd,
  input logic              intClk
);
  logic wrSeen;
  logic wrEvt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrSeen <= 1'b1;
    else       wrSeen <= wrN;
  end

  assign wrEvt = !csN && !wrN && wrSeen;

  // R3
  cs_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !busOe);

  // R2
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEvt |=> $stable({chanSel, rangeWide, bipolarSel, standby, fullPd}));

  // R7
  hi_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOe && byteHiSel) |->
      (busOut[DATA_W-1:DATA_W-4] == 4'h0) ||
      (busOut[DATA_W-1:DATA_W-4] == 4'hF && busOut[DATA_W-5]));

  // R8
  clk_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEvt && busIn[7]) |=> $stable(intClk));

  // R9
  pd_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEvt && busIn[7]) |=> busyN);

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyN) |-> $past(wrEvt));

  // R5
  conv_after_acq_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(converting) |-> $past(sampling));
endmodule

bind daq_host_front daq_host_front_chk chk (.*);

// File: tb/daq_host_front_test.sv
module daq_host_front_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, wrN = 1'b1, rdN = 1'b1, byteHiSel = 1'b0;
  logic [7:0]  busIn = '0;
  logic [7:0]  busOut;
  logic        busOe;
  logic [11:0] rawResult = '0;
  logic        busyN, sampling, converting;
  logic [2:0]  chanSel;
  logic        rangeWide, bipolarSel, standby, fullPd, intClk;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  daq_host_front uut (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .rdN(rdN),
    .byteHiSel(byteHiSel), .busIn(busIn), .busOut(busOut), .busOe(busOe),
    .rawResult(rawResult), .busyN(busyN), .sampling(sampling),
    .converting(converting), .chanSel(chanSel), .rangeWide(rangeWide),
    .bipolarSel(bipolarSel), .standby(standby), .fullPd(fullPd),
    .intClk(intClk)
  );

  // {ctrl byte, raw code, expected low byte, expected high byte}
  localparam logic [35:0] VEC [6] = '{
    {8'h01, 12'hABC, 8'hBC, 8'h0A},
    {8'h0A, 12'hABC, 8'hBC, 8'hFA},
    {8'h0B, 12'h7FF, 8'hFF, 8'h07},
    {8'h17, 12'h800, 8'h00, 8'h08},
    {8'h1C, 12'h800, 8'h00, 8'hF8},
    {8'h45, 12'h123, 8'h23, 8'h01}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] b, input logic cs);
    @(negedge clk);
    csN = cs; wrN = 1'b0; busIn = b;
    @(negedge clk);
    wrN = 1'b1; csN = 1'b1;
  endtask

  task automatic readByte(input logic hi, output logic [7:0] val, output logic oe, input logic cs);
    @(negedge clk);
    csN = cs; rdN = 1'b0; byteHiSel = hi;
    #5;
    val = busOut; oe = busOe;
    @(negedge clk);
    rdN = 1'b1; csN = 1'b1; byteHiSel = 1'b0;
  endtask

  task automatic countBusy(output int n);
    n = 0;
    while (!busyN && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       oe;
    int         n;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 chanSel", 16'(chanSel), 16'h0);
    check("R1 flags", 16'({rangeWide, bipolarSel, intClk, standby, fullPd}), 16'h0);
    check("R1 busyN/busOe", 16'({busyN, busOe}), 16'h2);
    readByte(1'b0, v, oe, 1'b0);
    check("R1 low byte", 16'(v), 16'h00);
    readByte(1'b1, v, oe, 1'b0);
    check("R1 high byte", 16'(v), 16'h00);

    // R2 R4 R6 R7 R10 vector walk
    for (int i = 0; i < 6; i++) begin
      rawResult = VEC[i][27:16];
      doWrite(VEC[i][35:28], 1'b0);
      check("R2 chanSel", 16'(chanSel), 16'(VEC[i][30:28]));
      check("R2 range/polarity", 16'({rangeWide, bipolarSel}), 16'(VEC[i][32:31]));
      countBusy(n);
      check("R4 busy cycles", 16'(n), 16'd18);
      readByte(1'b0, v, oe, 1'b0);
      check("R6 low byte", 16'(v), 16'(VEC[i][15:8]));
      check("R6 busOe", 16'(oe), 16'h1);
      readByte(1'b1, v, oe, 1'b0);
      check("R7 high byte", 16'(v), 16'(VEC[i][7:0]));
    end
    check("R8 intClk after mode 01", 16'(intClk), 16'h1);

    // R9 abort mid-conversion, old result 0x123 kept
    rawResult = 12'hFFF;
    doWrite(8'h46, 1'b0);
    repeat (9) @(negedge clk);
    check("R9 converting before abort", 16'(converting), 16'h1);
    doWrite(8'h80, 1'b0);
    check("R9 busyN after abort", 16'(busyN), 16'h1);
    check("R8 standby", 16'({standby, fullPd}), 16'h2);
    check("R8 intClk kept on standby", 16'(intClk), 16'h1);
    repeat (20) @(negedge clk);
    check("R9 no restart", 16'(busyN), 16'h1);
    readByte(1'b0, v, oe, 1'b0);
    check("R9 R10 old low byte", 16'(v), 16'h23);
    readByte(1'b1, v, oe, 1'b0);
    check("R9 old high byte", 16'(v), 16'h01);

    doWrite(8'hC0, 1'b0);
    check("R8 full power-down", 16'({standby, fullPd, intClk, busyN}), 16'h7);
    doWrite(8'h00, 1'b0);
    check("R8 external clock", 16'(intClk), 16'h0);
    countBusy(n);

    // R3 strobes ignored with chip-select high
    doWrite(8'h27, 1'b1);
    check("R3 write ignored chan", 16'(chanSel), 16'h0);
    check("R3 write ignored busy", 16'(busyN), 16'h1);
    readByte(1'b0, v, oe, 1'b1);
    check("R3 bus released", 16'(oe), 16'h0);

    // R5 host-ended acquisition
    rawResult = 12'h9A5;
    doWrite(8'h2B, 1'b0);
    repeat (10) @(negedge clk);
    check("R5 still sampling", 16'({sampling, busyN}), 16'h2);
    doWrite(8'h0B, 1'b1);
    repeat (4) @(negedge clk);
    check("R5 R3 cs-high write no end", 16'({sampling, converting}), 16'h2);
    doWrite(8'h0B, 1'b0);
    countBusy(n);
    check("R5 conversion cycles", 16'(n), 16'd12);
    readByte(1'b0, v, oe, 1'b0);
    check("R5 low byte", 16'(v), 16'hA5);
    readByte(1'b1, v, oe, 1'b0);
    check("R7 sign fill", 16'(v), 16'hF9);

    summary();
    $finish;
  end
endmodule